// File: doc/BRIEF.md
# Clock Mode Select and Divider

This block turns one fast base clock into three families of clock outputs: a group of CPU-domain clocks, a group of PCI-domain clocks and a single reference clock. A two-bit select picks the operating code. The codes are: outputs parked in high impedance, a slow CPU rate, a test mode, and a fast CPU rate. The CPU and PCI dividers count the same base clock from a common restart point. Every PCI rising edge therefore lands in the same base cycle as a CPU rising edge. Each output has an output-enable that models the tri-state driver.

The base clock runs at twelve times the nominal PCI frequency; the default `PCI_HALF` of 6 must remain a multiple of 6. With that rate, the PCI clock is the base divided by 12 in both active codes. The CPU clock is the base divided by 6 at the slow rate and by 4 at the fast rate, so the CPU:PCI ratio is 2 or 3 and every output keeps a 50% duty cycle.

In test mode, an external test clock and the crystal-rate reference are sampled through a two-stage synchronizer. The CPU outputs then toggle on every test-clock rising edge, giving divide by 2. The PCI outputs toggle on every third rising edge, giving divide by 6. The reference output carries the test clock itself.

A new select code is applied only at the end of the current PCI period. After it is applied, all clocks are held low for a quiet interval and then restart in phase. No shortened pulse is produced. The select input must be synchronous to the base clock.

Top module: `clkgen_modesel`

## Requirements
- R1: With code 00 applied, every enable (`cpu_oe_o`, `pci_oe_o`, `ref_oe_o`) is 0 and every clock output (CPU, PCI, reference) is held 0.
- R2: With code 01 running, each CPU output is high for `PCI_HALF/2` base cycles and then low for `PCI_HALF/2` base cycles. Each PCI output is high for `PCI_HALF` and then low for `PCI_HALF` base cycles.
- R3: With code 11 running, each CPU output is high for `PCI_HALF/3` and then low for `PCI_HALF/3` base cycles. Each PCI output is high for `PCI_HALF` and then low for `PCI_HALF` base cycles.
- R4: With code 10 running, each CPU output toggles once per test-clock rising edge, giving the test clock divided by 2. Each PCI output toggles once per three rising edges, giving divide by 6. The reference output follows the test clock, delayed by a fixed number of cycles.
- R5: In codes 01 and 11, the reference output reproduces the crystal-rate reference input with a fixed delay, so its high and low run lengths are unchanged.
- R6: In every running code, each rising edge of a PCI output occurs in the same base cycle as a rising edge of the CPU outputs.
- R7: When the code changes while the clocks run, the change waits for the end of the current PCI period. Every CPU and PCI pulse issued before the change has its full length.
- R8: Applying a code holds all clocks low for `2*PCI_HALF` divider steps after the applying edge. A step is one base cycle in codes 01 and 11 and one test-clock rising edge in code 10. From code 00, the applying edge is the first base edge after the select changes, so in an active code the first CPU and PCI rise comes on the `2*PCI_HALF+1`-th edge after it.
- R9: With any code other than 00 applied, all enables are 1 and all copies within the CPU group are identical; the same holds within the PCI group.
- R10: After reset, the block is in code 00 with all enables and clocks at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast base clock, twelve times the nominal PCI rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Operating code: 00 parked, 01 slow CPU, 10 test, 11 fast CPU |
| tclk_i | input | 1 | External test clock, sampled in code 10 |
| xref_i | input | 1 | Crystal-rate reference input |
| cpu_clk_o | output | N_CPU | CPU-domain clock copies |
| cpu_oe_o | output | N_CPU | Output enable per CPU clock |
| pci_clk_o | output | N_PCI | PCI-domain clock copies |
| pci_oe_o | output | N_PCI | Output enable per PCI clock |
| ref_clk_o | output | 1 | Reference clock output |
| ref_oe_o | output | 1 | Output enable of the reference clock |

## Verification
The bench builds the block with its defaults: two CPU copies, six PCI copies and a PCI half period of 6 base cycles. With these values the quiet gap of 13 cycles is longer than any CPU low run in any code. This lets the bench tell a freshly restarted waveform from the old one purely at the ports. A fixed seed picks the test-clock and reference half periods (1 to 3 and 2 to 4 cycles). These values give test-mode pulses both shorter and longer than the quiet interval's share of each PCI period, and the bench switches between randomly chosen codes at arbitrary phases of the running waveform.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_LO   = 2'b01,
    MODE_TEST = 2'b10,
    MODE_HI   = 2'b11
  } mode_e;

  // divider half periods in test mode, counted in test-clock rising edges
  localparam int unsigned TEST_CPU_HALF = 1;
  localparam int unsigned TEST_PCI_HALF = 3;

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkgen_div.sv
// Phase counter with a registered 50% output; high while the shown count is
// below the half period, restart from count zero whenever held.
module clkgen_div #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic [CW-1:0] half_i,
  output logic          clk_o,
  output logic          wrap_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic [CW:0]   span;
  logic          last_hit;

  assign span     = {half_i, 1'b0};
  assign last_hit = ({1'b0, cnt_q} == (span - 1'b1));
  assign wrap_o   = tick_i & last_hit;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (hold_i) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else begin
      out_d = (cnt_q < half_i);
      if (tick_i) cnt_d = last_hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;

  // R8: a held divider presents a low output on the following cycle
  p_held_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !clk_o);

  // R2: the running count never leaves one period of the selected divider
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |-> ({1'b0, cnt_q} < span));

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl import clkgen_pkg::*; #(
  parameter int unsigned PCI_HALF = 6,
  parameter int unsigned CW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          tclk_s_i,
  input  logic          wrap_i,
  output logic          hold_o,
  output logic          tick_o,
  output mode_e         mode_o,
  output logic          en_o,
  output logic [CW-1:0] cpu_half_o,
  output logic [CW-1:0] pci_half_o
);

  localparam int unsigned QUIET = 2 * PCI_HALF;
  localparam int unsigned QW    = $clog2(QUIET + 1);

  mode_e         mode_q, mode_d;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          tclk_d_q;
  logic          en_q, en_d;
  logic          pending, boundary, apply, quiet_on;

  assign quiet_on = (quiet_q != '0);
  assign pending  = (sel_i != mode_q);
  assign boundary = (mode_q == MODE_HIZ) | quiet_on | wrap_i;
  assign apply    = pending & boundary;
  assign tick_o   = (mode_q == MODE_TEST) ? (tclk_s_i & ~tclk_d_q) : 1'b1;
  assign hold_o   = apply | quiet_on | (mode_q == MODE_HIZ);

  always_comb begin
    mode_d  = mode_q;
    quiet_d = quiet_q;
    if (apply) begin
      mode_d  = mode_e'(sel_i);
      quiet_d = QW'(QUIET);
    end else if (quiet_on && tick_o) begin
      quiet_d = quiet_q - 1'b1;
    end
    en_d = (mode_d != MODE_HIZ);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_HIZ;
      quiet_q  <= '0;
      tclk_d_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      quiet_q  <= quiet_d;
      tclk_d_q <= tclk_s_i;
      en_q     <= en_d;
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_LO: begin
        cpu_half_o = CW'(PCI_HALF / 2);
        pci_half_o = CW'(PCI_HALF);
      end
      MODE_HI: begin
        cpu_half_o = CW'(PCI_HALF / 3);
        pci_half_o = CW'(PCI_HALF);
      end
      MODE_TEST: begin
        cpu_half_o = CW'(TEST_CPU_HALF);
        pci_half_o = CW'(TEST_PCI_HALF);
      end
      default: begin
        cpu_half_o = CW'(PCI_HALF);
        pci_half_o = CW'(PCI_HALF);
      end
    endcase
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;

  // R8: every newly applied code restarts the full quiet interval
  p_quiet_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> (quiet_q == QW'(QUIET)));

  // R7: a running waveform keeps its code until the PCI period ends
  p_wait_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_HIZ && !quiet_on && !wrap_i) |=> $stable(mode_q));

  // R1: enables stay low while parked
  p_parked_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HIZ) |-> !en_o);

endmodule

// File: rtl/clkgen_modesel.sv
module clkgen_modesel import clkgen_pkg::*; #(
  parameter int unsigned N_CPU       = 2,
  parameter int unsigned N_PCI       = 6,
  parameter int unsigned PCI_HALF    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             tclk_i,
  input  logic             xref_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_CPU-1:0] cpu_oe_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic [N_PCI-1:0] pci_oe_o,
  output logic             ref_clk_o,
  output logic             ref_oe_o
);

  localparam int unsigned CW = $clog2(2 * PCI_HALF);

  logic          tclk_s, xref_s;
  logic          hold, tick, en;
  logic          cpu_div, pci_div, cpu_wrap, pci_wrap;
  logic [CW-1:0] cpu_half, pci_half;
  mode_e         mode;
  logic          ref_q, ref_d;

  clkgen_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tclk_i, xref_i}),
    .q_o    ({tclk_s, xref_s})
  );

  clkgen_ctrl #(.PCI_HALF(PCI_HALF), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .tclk_s_i   (tclk_s),
    .wrap_i     (pci_wrap),
    .hold_o     (hold),
    .tick_o     (tick),
    .mode_o     (mode),
    .en_o       (en),
    .cpu_half_o (cpu_half),
    .pci_half_o (pci_half)
  );

  clkgen_div #(.CW(CW)) u_cpu_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_i (tick),
    .half_i (cpu_half),
    .clk_o  (cpu_div),
    .wrap_o (cpu_wrap)
  );

  clkgen_div #(.CW(CW)) u_pci_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_i (tick),
    .half_i (pci_half),
    .clk_o  (pci_div),
    .wrap_o (pci_wrap)
  );

  always_comb begin
    if (hold)                   ref_d = 1'b0;
    else if (mode == MODE_TEST) ref_d = tclk_s;
    else                        ref_d = xref_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu
    assign cpu_clk_o[gi] = cpu_div;
    assign cpu_oe_o[gi]  = en;
  end

  for (genvar gj = 0; gj < N_PCI; gj++) begin : g_pci
    assign pci_clk_o[gj] = pci_div;
    assign pci_oe_o[gj]  = en;
  end

  assign ref_clk_o = ref_q;
  assign ref_oe_o  = en;

  // R6: PCI rising edges only come together with CPU rising edges
  p_edge_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_clk_o[0]) |-> $rose(cpu_clk_o[0]));

  // R7: the CPU period boundary is reached whenever the PCI period ends
  p_wrap_nest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_wrap && !hold) |-> cpu_wrap);

  // R1: disabled outputs are parked low
  p_disabled_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_oe_o |-> (!ref_clk_o && cpu_clk_o == '0 && pci_clk_o == '0));

endmodule

// File: tb/clkgen_modesel_tb.sv
module clkgen_modesel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_CPU      = 2;
  localparam int N_PCI      = 6;
  localparam int PCI_HALF   = 6;
  localparam int QUIET      = 2 * PCI_HALF;
  localparam logic [1:0] M_HIZ = 2'b00, M_LO = 2'b01, M_TEST = 2'b10, M_HI = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = M_HIZ;
  logic tclk = 1'b0, xref = 1'b0;
  logic [N_CPU-1:0] cpu_clk, cpu_oe;
  logic [N_PCI-1:0] pci_clk, pci_oe;
  logic ref_clk, ref_oe;

  int vec_cnt = 0;
  int err_cnt = 0;
  int th = 0;
  int xh = 0;
  logic [1:0] cur = M_HIZ;

  clkgen_modesel #(.N_CPU(N_CPU), .N_PCI(N_PCI), .PCI_HALF(PCI_HALF)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sel_i     (sel),
    .tclk_i    (tclk),
    .xref_i    (xref),
    .cpu_clk_o (cpu_clk),
    .cpu_oe_o  (cpu_oe),
    .pci_clk_o (pci_clk),
    .pci_oe_o  (pci_oe),
    .ref_clk_o (ref_clk),
    .ref_oe_o  (ref_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #1;
    forever begin
      repeat (th) @(negedge clk);
      tclk = ~tclk;
    end
  end

  initial begin
    #1;
    forever begin
      repeat (xh) @(negedge clk);
      xref = ~xref;
    end
  end

  function automatic int exp_cpu_run(input logic [1:0] m);
    case (m)
      M_LO:    return PCI_HALF / 2;
      M_HI:    return PCI_HALF / 3;
      M_TEST:  return 2 * th;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pci_run(input logic [1:0] m);
    case (m)
      M_LO, M_HI: return PCI_HALF;
      M_TEST:     return 6 * th;
      default:    return 0;
    endcase
  endfunction

  function automatic int exp_ref_run(input logic [1:0] m);
    return (m == M_TEST) ? th : xh;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit all_quiet();
    return (cpu_clk == '0) && (pci_clk == '0) && !ref_clk &&
           (cpu_oe == '0) && (pci_oe == '0) && !ref_oe;
  endfunction

  function automatic bit all_enabled();
    return (cpu_oe == '1) && (pci_oe == '1) && ref_oe;
  endfunction

  // switch code, checking that the old waveform is not cut short
  task automatic go(input logic [1:0] nm);
    logic [1:0] old;
    bit cp, pp, seen_c, seen_p, done, bad;
    int hc, hp, lc, lp, n, ec, ep;
    old = cur;
    sel = nm;
    cur = nm;
    if (nm != old) begin
      cp = cpu_clk[0]; pp = pci_clk[0];
      seen_c = 0; seen_p = 0; done = 0;
      hc = 0; hp = 0; lc = 0; lp = 0; n = 0;
      ec = exp_cpu_run(old); ep = exp_pci_run(old);
      while (!done && n < 3000) begin
        @(negedge clk);
        n++;
        if (nm == M_HIZ) begin
          if (cpu_oe == '0) begin
            done = 1;
            chk(all_quiet(), "R1 parked at entry", int'(cpu_clk[0]), 0);
          end
        end else if (cpu_clk[0] && !cp && lc >= QUIET + 1) begin
          done = 1;
          chk(pci_clk[0] && !pp, "R6 restart edges together", int'(pci_clk[0]), 1);
          chk(lp >= QUIET + 1, "R8 quiet gap on PCI", lp, QUIET + 1);
          chk(all_enabled(), "R9 enables after switch", int'(cpu_oe[0]), 1);
          if (old == M_HIZ && nm != M_TEST)
            chk(n == QUIET + 2, "R8 start latency from parked", n, QUIET + 2);
        end
        if (!done) begin
          if (cpu_clk[0]) begin
            if (!cp) begin seen_c = 1; hc = 0; end
            hc++; lc = 0;
          end else begin
            if (cp && seen_c && old != M_HIZ)
              chk(hc == ec, "R7 CPU pulse before switch", hc, ec);
            lc++;
          end
          if (pci_clk[0]) begin
            if (!pp) begin seen_p = 1; hp = 0; end
            hp++; lp = 0;
          end else begin
            if (pp && seen_p && old != M_HIZ)
              chk(hp == ep, "R7 PCI pulse before switch", hp, ep);
            lp++;
          end
        end
        cp = cpu_clk[0]; pp = pci_clk[0];
      end
      if (!done) chk(0, "R7 switch never completed", n, 0);
      if (nm == M_HIZ) begin
        bad = 0;
        repeat (25) begin
          @(negedge clk);
          if (!all_quiet()) bad = 1;
        end
        chk(!bad, "R1 parked window", int'(bad), 0);
      end
    end
  endtask

  // steady-state run lengths, alignment and fan-out
  task automatic measure(input logic [1:0] m, input int ncyc);
    bit cp, pp, rp, rstart, fan_bad, found;
    int cr, pr, rr, n, ec, ep, er;
    string tg, rtg;
    tg  = (m == M_LO) ? "R2" : (m == M_HI) ? "R3" : "R4";
    rtg = (m == M_TEST) ? "R4 ref" : "R5 ref";
    ec = exp_cpu_run(m); ep = exp_pci_run(m); er = exp_ref_run(m);
    pp = pci_clk[0]; cp = cpu_clk[0]; n = 0; found = 0;
    while (!found && n < 2000) begin
      @(negedge clk);
      n++;
      if (pci_clk[0] && !pp) found = 1;
      else begin pp = pci_clk[0]; cp = cpu_clk[0]; end
    end
    chk(found, {tg, " PCI edge seen"}, int'(found), 1);
    chk(cpu_clk[0] && !cp, "R6 CPU rises with PCI", int'(cpu_clk[0]), 1);
    cp = 1; pp = 1; cr = 1; pr = 1; rp = ref_clk; rr = 1; rstart = 0; fan_bad = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (pci_clk[0] && !pp)
        chk(cpu_clk[0] && !cp, "R6 CPU rises with PCI", int'(cpu_clk[0]), 1);
      if (cpu_clk[0] == cp) cr++;
      else begin chk(cr == ec, {tg, " CPU run"}, cr, ec); cr = 1; end
      if (pci_clk[0] == pp) pr++;
      else begin chk(pr == ep, {tg, " PCI run"}, pr, ep); pr = 1; end
      if (ref_clk == rp) rr++;
      else begin
        if (rstart) chk(rr == er, rtg, rr, er);
        rstart = 1; rr = 1;
      end
      if (cpu_clk != {N_CPU{cpu_clk[0]}} || pci_clk != {N_PCI{pci_clk[0]}} || !all_enabled())
        fan_bad = 1;
      cp = cpu_clk[0]; pp = pci_clk[0]; rp = ref_clk;
    end
    chk(!fan_bad, "R9 enables and copies", int'(fan_bad), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic [1:0] nm;
    void'($urandom(32'd20417));
    th = 1 + int'($urandom % 3);
    xh = 2 + int'($urandom % 3);
    repeat (3) @(negedge clk);
    chk(all_quiet(), "R10 in reset", int'(cpu_clk[0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(all_quiet(), "R10 after reset", int'(cpu_oe[0]), 0);

    // directed sequence through every code
    go(M_LO);   measure(M_LO, 8 * exp_pci_run(M_LO));
    go(M_HI);   measure(M_HI, 8 * exp_pci_run(M_HI));
    go(M_TEST); measure(M_TEST, 8 * exp_pci_run(M_TEST));
    go(M_HIZ);
    go(M_HI);   measure(M_HI, 6 * exp_pci_run(M_HI));
    go(M_LO);   measure(M_LO, 6 * exp_pci_run(M_LO));
    go(M_HIZ);
    go(M_TEST); measure(M_TEST, 4 * exp_pci_run(M_TEST));

    // random code sequence, switched at arbitrary phases
    for (int k = 0; k < 14; k++) begin
      nm = 2'($urandom % 4);
      repeat (int'($urandom % 7)) @(negedge clk);
      go(nm);
      if (nm != M_HIZ) measure(nm, 4 * exp_pci_run(nm));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule